// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from one of two input clock streams: an internal bus clock or an external display clock. Each input stream reaches the block as a one-cycle tick on a fast system clock (`clk`). A control bit picks which stream drives the divider. The divisor is an unsigned fixed-point value with eight integer bits and four fractional bits. A phase accumulator spreads the fraction across successive output periods. Every period therefore lasts either the integer part or one more input cycle, and the long-run average equals the programmed ratio.

The output waveform comes from two edge positions, a rise and a fall, counted in half input cycles from the start of each period. This gives the duty cycle half-cycle resolution. For every input cycle the block presents two level bits, one for the first half and one for the second half, ready for a double-rate output cell. It also presents a one-clock strobe that marks the start of each period and serves as a pixel enable. A further control bit inverts the level bits.

Two words are written through a simple register write port: one holds the divisor and the control bits, the other holds the edge positions. Any write restarts the divider cleanly.

The sequencer has two states. In `ST_RESTART` no period is active: the outputs rest at the idle level and the phase accumulator is clear. In `ST_RUN` a period is in progress. Transitions:
- `ST_RESTART` → `ST_RUN` on the first selected tick, which opens a period.
- `ST_RUN` → `ST_RUN` on each tick. The position advances, or a new period opens after the last position.
- Any state → `ST_RESTART` on a register write. A write takes priority over a tick in the same cycle.

Top module: `dclk_frac_div`

## Requirements
- R1: After reset the divisor is 0x010 (1.0), the rise position is 0, the fall position is 1, both control bits are 0, `pix_lvl` is 2'b00 and `pix_stb` is 0.
- R2: A write with `wr_addr`=0 loads the following fields:
  - divisor from bits 11:0, where bits 11:4 are the integer part and bits 3:0 are sixteenths;
  - external-clock select from bit 16;
  - output invert from bit 17.

  A write with `wr_addr`=1 loads the fall position from bits 24:16 and the rise position from bits 8:0.
- R3: Only the tick of the selected source advances the divider: `ext_tick` when the select bit is 1, `bus_tick` when it is 0. The other tick input has no effect on any output.
- R4: With an integer divisor N (fraction 0), a period opens on the first selected tick after a restart and on every Nth selected tick after that.
- R5: With fraction f, each new period adds f to a 4-bit accumulator. The period lasts N+1 ticks when that addition carries and N ticks otherwise. Sixteen consecutive periods therefore span 16·N+f ticks.
- R6: A divisor whose integer part is zero is treated as having integer part 1, and its fraction is kept.
- R7: In a period at position p (ticks since it opened, starting at 0), half index h=2p (bit 0) and h=2p+1 (bit 1) are high (before inversion) exactly when rise ≤ h < fall.
- R8: When fall ≤ rise the un-inverted level is low for the whole period.
- R9: With the invert bit set, both level bits are inverted, including the idle level.
- R10: A write of either word clears the accumulator and returns to `ST_RESTART`. Until the next selected tick, both level bits show the idle level (the invert bit) and no strobe occurs. A tick in the same cycle as a write is ignored.
- R11: `pix_stb` is high for exactly the one `clk` cycle after the tick that opens a period. The level bits change only on the edge of a selected tick or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than either input stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: divisor and control word, 1: edge word |
| wr_data | input | 32 | Write data |
| bus_tick | input | 1 | One-cycle tick per internal bus clock cycle |
| ext_tick | input | 1 | One-cycle tick per external display clock cycle |
| pix_lvl | output | 2 | Pixel clock level for the first (bit 0) and second (bit 1) half of the current input cycle |
| pix_stb | output | 1 | One-cycle strobe at the start of each output period |

## Verification
The assertions assume that a tick is a single-cycle pulse in the `clk` domain and that register writes arrive only as single-cycle `wr_en` strobes. Under those assumptions the period length, the idle level after a write and the strobe timing follow from the ports alone. The stimulus drives every input once per cycle, half a period away from the sampling edge. It holds ticks for one cycle with gaps of zero to several cycles, and places writes both between ticks and on a tick cycle, so that the write-priority case is covered.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    typedef enum logic [0:0] {
        ST_RESTART = 1'b0,
        ST_RUN     = 1'b1
    } dclk_state_e;

    localparam logic ADDR_DIV  = 1'b0;
    localparam logic ADDR_EDGE = 1'b1;

    localparam int SEL_BIT  = 16;
    localparam int INV_BIT  = 17;
    localparam int FALL_LSB = 16;

endpackage

// File: rtl/dclk_cfg_regs.sv
module dclk_cfg_regs
    import dclk_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [INT_W+FRAC_W-1:0] div_q,
    output logic [EDGE_W-1:0]       rise_q,
    output logic [EDGE_W-1:0]       fall_q,
    output logic                    ext_sel_q,
    output logic                    inv_q
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(1) << FRAC_W;

    wire unused_bits = ^{wr_data[DATA_W-1:FALL_LSB+EDGE_W], wr_data[SEL_BIT-1:DIV_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= DIV_RESET;
            rise_q    <= '0;
            fall_q    <= EDGE_W'(1);
            ext_sel_q <= 1'b0;
            inv_q     <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_DIV) begin
                div_q     <= wr_data[DIV_W-1:0];
                ext_sel_q <= wr_data[SEL_BIT];
                inv_q     <= wr_data[INV_BIT];
            end else begin
                rise_q <= wr_data[EDGE_W-1:0];
                fall_q <= wr_data[FALL_LSB+EDGE_W-1:FALL_LSB];
            end
        end
    end

endmodule

// File: rtl/dclk_period_gen.sv
module dclk_period_gen
    import dclk_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    tick,
    input  logic [INT_W+FRAC_W-1:0] div,
    output logic [INT_W:0]          pos_q,
    output logic [INT_W:0]          len_q,
    output logic                    running,
    output logic                    start_stb
);
    localparam int POS_W = INT_W + 1;

    dclk_state_e state_q, state_d;

    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [POS_W-1:0]  n_eff;
    logic [FRAC_W:0]   acc_sum;
    logic [FRAC_W-1:0] acc_q;
    logic              at_end;
    logic              open_period;

    always_comb begin
        int_part    = div[INT_W+FRAC_W-1:FRAC_W];
        frac_part   = div[FRAC_W-1:0];
        n_eff       = (int_part == '0) ? POS_W'(1) : POS_W'(int_part);
        acc_sum     = {1'b0, acc_q} + {1'b0, frac_part};
        at_end      = (pos_q == len_q - POS_W'(1));
        open_period = tick && ((state_q == ST_RESTART) || at_end);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_RESTART;
        end else begin
            unique case (state_q)
                ST_RESTART: if (tick) state_d = ST_RUN;
                ST_RUN:     state_d = ST_RUN;
                default:    state_d = ST_RESTART;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESTART;
        else        state_q <= state_d;
    end

    // counters and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            pos_q     <= '0;
            len_q     <= POS_W'(1);
            start_stb <= 1'b0;
        end else if (restart) begin
            acc_q     <= '0;
            pos_q     <= '0;
            start_stb <= 1'b0;
        end else if (open_period) begin
            acc_q     <= acc_sum[FRAC_W-1:0];
            len_q     <= n_eff + POS_W'(acc_sum[FRAC_W]);
            pos_q     <= '0;
            start_stb <= 1'b1;
        end else begin
            if (tick) pos_q <= pos_q + POS_W'(1);
            start_stb <= 1'b0;
        end
    end

    assign running = (state_q == ST_RUN);

endmodule

// File: rtl/dclk_edge_shaper.sv
module dclk_edge_shaper #(
    parameter int POS_W  = 9,
    parameter int EDGE_W = 9
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [EDGE_W-1:0] rise,
    input  logic [EDGE_W-1:0] fall,
    input  logic              inv,
    input  logic              running,
    output logic [1:0]        lvl
);
    localparam int HALF_W = POS_W + 1;
    localparam int CMP_W  = HALF_W + EDGE_W;

    for (genvar k = 0; k < 2; k++) begin : g_half
        logic [CMP_W-1:0] half_idx;
        logic             high;
        always_comb begin
            half_idx = CMP_W'({pos, 1'b0}) + CMP_W'(k);
            high     = (half_idx >= CMP_W'(rise)) && (half_idx < CMP_W'(fall));
            lvl[k]   = running ? (high ^ inv) : inv;
        end
    end

endmodule

// File: rtl/dclk_frac_div.sv
module dclk_frac_div #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_tick,
    input  logic              ext_tick,
    output logic [1:0]        pix_lvl,
    output logic              pix_stb
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int POS_W = INT_W + 1;

    logic [DIV_W-1:0]  div_q;
    logic [EDGE_W-1:0] rise_q;
    logic [EDGE_W-1:0] fall_q;
    logic              ext_sel_q;
    logic              inv_q;
    logic              cur_tick;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  len_q;
    logic              running;

    dclk_cfg_regs #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W), .DATA_W(DATA_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_q(div_q), .rise_q(rise_q), .fall_q(fall_q),
        .ext_sel_q(ext_sel_q), .inv_q(inv_q)
    );

    assign cur_tick = ext_sel_q ? ext_tick : bus_tick;

    dclk_period_gen #(
        .INT_W(INT_W), .FRAC_W(FRAC_W)
    ) per_i (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .tick(cur_tick),
        .div(div_q), .pos_q(pos_q), .len_q(len_q), .running(running),
        .start_stb(pix_stb)
    );

    dclk_edge_shaper #(
        .POS_W(POS_W), .EDGE_W(EDGE_W)
    ) shp_i (
        .pos(pos_q), .rise(rise_q), .fall(fall_q), .inv(inv_q),
        .running(running), .lvl(pix_lvl)
    );

endmodule

// File: rtl/dclk_frac_div_chk.sv
module dclk_frac_div_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    cur_tick,
    input logic                    pix_stb,
    input logic [1:0]              pix_lvl,
    input logic                    inv_q,
    input logic [EDGE_W-1:0]       rise_q,
    input logic [EDGE_W-1:0]       fall_q,
    input logic [INT_W+FRAC_W-1:0] div_q,
    input logic [INT_W:0]          pos_q,
    input logic [INT_W:0]          len_q,
    input logic                    running
);
    localparam int POS_W = INT_W + 1;

    logic [POS_W-1:0]  n_ref;
    logic [FRAC_W-1:0] f_ref;
    assign n_ref = (div_q[INT_W+FRAC_W-1:FRAC_W] == '0) ? POS_W'(1)
                                                        : POS_W'(div_q[INT_W+FRAC_W-1:FRAC_W]);
    assign f_ref = div_q[FRAC_W-1:0];

    // R4: position stays inside the current period
    p_pos_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (pos_q < len_q));

    // R5 / R6: period is N or N+1 ticks, N+1 only with a nonzero fraction
    p_len_choice_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((len_q == n_ref) || ((len_q == n_ref + POS_W'(1)) && (f_ref != '0))));

    // R8: empty high window keeps the level at the idle value
    p_empty_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q <= rise_q) |-> (pix_lvl == {2{inv_q}}));

    // R10: after a write, no strobe and the idle level
    p_write_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!pix_stb && (pix_lvl == {2{inv_q}})));

    // R11: strobe only follows a selected tick that was not overridden by a write
    p_stb_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> ($past(cur_tick) && !$past(wr_en)));

    // R11: level holds across cycles with neither tick nor write
    p_level_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_tick && !wr_en) |=> $stable(pix_lvl));

endmodule

bind dclk_frac_div dclk_frac_div_chk #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cur_tick(cur_tick),
    .pix_stb(pix_stb), .pix_lvl(pix_lvl), .inv_q(inv_q), .rise_q(rise_q),
    .fall_q(fall_q), .div_q(div_q), .pos_q(pos_q), .len_q(len_q),
    .running(running)
);

// File: tb/dclk_frac_div_tb_top.sv
module dclk_frac_div_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        bus_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [1:0]  pix_lvl;
    logic        pix_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dclk_frac_div dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bus_tick(bus_tick), .ext_tick(ext_tick),
        .pix_lvl(pix_lvl), .pix_stb(pix_stb)
    );

    // behavioural reference
    int m_div, m_rise, m_fall, m_pos, m_len, m_acc;
    bit m_ext, m_inv, m_run, m_stb, m_ticked;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 16; m_rise = 0; m_fall = 1; m_ext = 0; m_inv = 0;
            m_run = 0; m_pos = 0; m_len = 1; m_acc = 0; m_stb = 0; m_ticked = 0;
        end else begin
            bit t;
            t = m_ext ? ext_tick : bus_tick;
            m_stb = 0; m_ticked = 0;
            if (wr_en) begin
                if (wr_addr == 1'b0) begin
                    m_div = int'(wr_data & 32'hfff);
                    m_ext = wr_data[16];
                    m_inv = wr_data[17];
                end else begin
                    m_rise = int'(wr_data[8:0]);
                    m_fall = int'(wr_data[24:16]);
                end
                m_run = 0; m_acc = 0; m_pos = 0;
            end else if (t) begin
                int n;
                n = m_div / 16;
                if (n == 0) n = 1;
                m_ticked = 1;
                if (!m_run || m_pos == m_len - 1) begin
                    m_acc = m_acc + (m_div % 16);
                    m_len = n + ((m_acc >= 16) ? 1 : 0);
                    m_acc = m_acc % 16;
                    m_pos = 0; m_stb = 1; m_run = 1;
                end else begin
                    m_pos = m_pos + 1;
                end
            end
        end
    end

    function automatic logic [1:0] exp_lvl();
        logic [1:0] r;
        for (int k = 0; k < 2; k++) begin
            int h;
            h = 2 * m_pos + k;
            r[k] = m_run ? (((h >= m_rise) && (h < m_fall)) ^ m_inv) : m_inv;
        end
        return r;
    endfunction

    // per-cycle comparison and measurement counters
    bit cnt_en = 0;
    int stb_cnt = 0;
    int hi_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pix_stb !== m_stb) begin
                errors++;
                $display("FAIL R4/R11 stb: actual %b expected %b at %0t", pix_stb, m_stb, $time);
            end
            checks++;
            if (pix_lvl !== exp_lvl()) begin
                errors++;
                $display("FAIL R7 lvl: actual %b expected %b at %0t", pix_lvl, exp_lvl(), $time);
            end
            if (cnt_en) begin
                stb_cnt += int'(pix_stb);
                if (m_ticked) hi_cnt += $countones(pix_lvl ^ {2{m_inv}});
            end
        end
    end

    task automatic cyc(input bit b, input bit e, input bit we, input bit a, input logic [31:0] d);
        @(negedge clk);
        #1;
        bus_tick = b; ext_tick = e; wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, '0);
    endtask

    task automatic wr(input bit a, input logic [31:0] d);
        cyc(0, 0, 1, a, d);
        idle();
    endtask

    task automatic bus_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0, 0, '0);
            for (int g = 0; g < gap; g++) idle();
        end
        idle();
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_count();
        stb_cnt = 0; hi_cnt = 0; cnt_en = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle();
        // R1: reset state
        chk("R1 reset lvl", int'(pix_lvl), 0);
        chk("R1 reset stb", int'(pix_stb), 0);
        // R1 / R7: default 1.0 divisor with fall 1 -> first half high
        cyc(1, 0, 0, 0, '0);
        idle();
        chk("R1 default lvl", int'(pix_lvl), 1);
        chk("R1 default stb", int'(pix_stb), 1);

        // R2 / R4: integer divisor 4, 50% duty with fall=4
        wr(1'b0, 32'h0000_0040);
        wr(1'b1, 32'h0004_0000);
        start_count();
        bus_ticks(40, 1);
        cnt_en = 0;
        chk("R4 periods in 40 ticks", stb_cnt, 10);
        chk("R7 high halves N=4", hi_cnt, 40);

        // R5: divisor 3.25 -> 16 periods in 52 ticks
        wr(1'b0, 32'h0000_0034);
        start_count();
        bus_ticks(52, 0);
        cnt_en = 0;
        chk("R5 periods in 52 ticks", stb_cnt, 16);

        // R6: divisor 0.5 -> 1.5 average, 6 periods in 8 ticks
        wr(1'b0, 32'h0000_0008);
        start_count();
        bus_ticks(8, 2);
        cnt_en = 0;
        chk("R6 periods in 8 ticks", stb_cnt, 6);

        // R7: half resolution, N=3, rise 1, fall 4
        wr(1'b0, 32'h0000_0030);
        wr(1'b1, 32'h0004_0001);
        cyc(1, 0, 0, 0, '0); idle();
        chk("R7 pos0 lvl", int'(pix_lvl), 2);
        cyc(1, 0, 0, 0, '0); idle();
        chk("R7 pos1 lvl", int'(pix_lvl), 3);
        cyc(1, 0, 0, 0, '0); idle();
        chk("R7 pos2 lvl", int'(pix_lvl), 0);

        // R3: external select, bus ticks ignored
        wr(1'b0, 32'h0001_0020);
        start_count();
        bus_ticks(10, 0);
        cnt_en = 0;
        chk("R3 bus ignored stb", stb_cnt, 0);
        chk("R3 bus ignored lvl", int'(pix_lvl), 0);
        start_count();
        for (int i = 0; i < 10; i++) begin cyc(0, 1, 0, 0, '0); idle(); end
        cnt_en = 0;
        chk("R3 ext ticks periods", stb_cnt, 5);

        // R9: invert, idle level becomes 2'b11
        wr(1'b0, 32'h0002_0020);
        chk("R9 idle inverted", int'(pix_lvl), 3);
        bus_ticks(12, 1);

        // R8: fall below rise -> never high
        wr(1'b0, 32'h0000_0040);
        wr(1'b1, 32'h0003_0005);
        start_count();
        bus_ticks(12, 0);
        cnt_en = 0;
        chk("R8 high halves", hi_cnt, 0);

        // R10: write mid-period restarts, tick with write ignored
        wr(1'b1, 32'h0004_0000);
        bus_ticks(2, 0);
        cyc(1, 0, 1, 1'b1, 32'h0004_0000);
        idle();
        chk("R10 no stb on write+tick", int'(pix_stb), 0);
        chk("R10 idle after write", int'(pix_lvl), 0);
        cyc(1, 0, 0, 0, '0); idle();
        chk("R10 restart opens period", int'(pix_stb), 1);
        idle();
        chk("R11 stb one cycle", int'(pix_stb), 0);
        bus_ticks(6, 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule